// File: doc/BRIEF.md
# Page Table Entry Fill Engine

This block carries out a single fill command. It writes a run of 64-bit page table entries to memory, so software does not have to store each entry by hand. The command arrives as a stream of nine 32-bit words. The words give a destination address, a 64-bit flag mask, a 64-bit starting value, a 64-bit stride and an entry count.

Once the command is complete, the engine writes one 64-bit entry for each count, as two 32-bit memory writes. The destinations are consecutive 8-byte slots. Entry i carries the starting value plus i times the stride, with the flag mask ORed in. Memory backpressure holds the current write in place. A one-cycle done pulse marks the end of the command.

The controller is a five-state machine:

- **COLLECT** takes command words. On the ninth word it goes to ARM.
- **ARM** loads the running address, value and remaining count. It goes to DONE when the count is zero, and to WR_LO otherwise.
- **WR_LO** issues the low word. It goes to WR_HI once that write is accepted.
- **WR_HI** issues the high word. Once that write is accepted, it returns to WR_LO if more entries remain, and goes to DONE after the last entry.
- **DONE** raises done for one cycle and returns to COLLECT.

Top module: `pte_fill_engine`

## Requirements
- R1: Command words are taken only when cmd_valid and cmd_ready are both high. cmd_ready is high only in COLLECT, so words offered while a command runs are ignored. The word order is: destination low, destination high, flags low, flags high, value low, value high, stride low, stride high, count.
- R2: Entry i is written at the destination plus 8*i, with destination bits [1:0] forced to zero. Every write address is therefore a multiple of 4.
- R3: Each entry is two writes. The low word (entry bits 31:0) goes to the entry address first. The high word (bits 63:32) follows at the entry address plus 4.
- R4: Entry i equals (value + i*stride) | flags. A zero value with a zero stride therefore writes the flag mask alone.
- R5: The entry count is bits [18:0] of the ninth word. Bits [31:19] are ignored, so at most 0x7FFFF entries are written per command.
- R6: A count of zero issues no write. done pulses in the second cycle after the ninth word is accepted.
- R7: While wr_valid is high and wr_ready is low, wr_valid stays high and wr_addr and wr_data hold their values.
- R8: done is high for exactly one cycle, the cycle after the final write is accepted. cmd_ready rises in the next cycle.
- R9: Address and value arithmetic wraps modulo 2^64 and raises no error.
- R10: After reset, or a reset in the middle of a command, cmd_ready is 1, wr_valid and done are 0, and word capture restarts at the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_dword | input | 32 | Command word |
| cmd_ready | output | 1 | Engine accepts a command word |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 64 | Byte address of the write |
| wr_data | output | 32 | Write data |
| done | output | 1 | One-cycle pulse at the end of a command |

## Verification
Each kind of internal fault shows up at the ports at a predictable time:

- **Wrong running value or stride sum:** the second entry's data is wrong, two accepted writes after the first.
- **Address step fault:** appears on the write that follows the first acceptance, because every accepted write must be followed by a write exactly 4 bytes higher, or by no write at all.
- **Count or state-machine fault:** shows as a missing or extra write, a done pulse that comes early, late or lasts too long, or cmd_ready returning at the wrong time. Any of these is visible within one cycle of the final expected acceptance.
- **Capture-index fault:** mixes up the command fields, so the very first write carries a wrong address or wrong data.

// File: rtl/pte_fill_pkg.sv
package pte_fill_pkg;
    localparam int ADDR_W     = 64;
    localparam int WORD_W     = 32;
    localparam int COUNT_W    = 19;
    localparam int CMD_WORDS  = 9;
    localparam int ENTRY_BYTES = 8;

    typedef enum logic [2:0] {
        S_COLLECT = 3'd0,
        S_ARM     = 3'd1,
        S_WR_LO   = 3'd2,
        S_WR_HI   = 3'd3,
        S_DONE    = 3'd4
    } fill_state_e;
endpackage

// File: rtl/pte_cmd_capture.sv
module pte_cmd_capture #(
    parameter int AW        = 64,
    parameter int DW        = 32,
    parameter int CNT_W     = 19,
    parameter int NUM_WORDS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [DW-1:0]    word,
    output logic             last_word,
    output logic [AW-1:0]    dest,
    output logic [AW-1:0]    flags,
    output logic [AW-1:0]    value,
    output logic [AW-1:0]    stride,
    output logic [CNT_W-1:0] count
);
    localparam int IW = $clog2(NUM_WORDS);
    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_WORDS - 1);

    logic [IW-1:0]   idx_q;
    logic [DW-1:3-1] dest_lo_q;
    logic [DW-1:0]   dest_hi_q, flg_lo_q, flg_hi_q, val_lo_q, val_hi_q, str_lo_q, str_hi_q;
    logic [CNT_W-1:0] cnt_q;

    assign last_word = take && (idx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (take) begin
            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            unique case (idx_q)
                IW'(0): dest_lo_q <= word[DW-1:2];
                IW'(1): dest_hi_q <= word;
                IW'(2): flg_lo_q  <= word;
                IW'(3): flg_hi_q  <= word;
                IW'(4): val_lo_q  <= word;
                IW'(5): val_hi_q  <= word;
                IW'(6): str_lo_q  <= word;
                IW'(7): str_hi_q  <= word;
                default: cnt_q    <= word[CNT_W-1:0];
            endcase
        end
    end

    assign dest   = {dest_hi_q, dest_lo_q, 2'b00};
    assign flags  = {flg_hi_q, flg_lo_q};
    assign value  = {val_hi_q, val_lo_q};
    assign stride = {str_hi_q, str_lo_q};
    assign count  = cnt_q;
endmodule

// File: rtl/pte_fill_fsm.sv
module pte_fill_fsm
    import pte_fill_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        last_word,
    input  logic        count_zero,
    input  logic        last_entry,
    input  logic        wr_ready,
    output fill_state_e state,
    output logic        cmd_ready,
    output logic        wr_valid,
    output logic        sel_hi,
    output logic        load,
    output logic        advance,
    output logic        done
);
    fill_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_COLLECT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_COLLECT: if (last_word) state_d = S_ARM;
            S_ARM:     state_d = count_zero ? S_DONE : S_WR_LO;
            S_WR_LO:   if (wr_ready) state_d = S_WR_HI;
            S_WR_HI:   if (wr_ready) state_d = last_entry ? S_DONE : S_WR_LO;
            S_DONE:    state_d = S_COLLECT;
            default:   state_d = S_COLLECT;
        endcase
    end

    always_comb begin
        cmd_ready = (state_q == S_COLLECT);
        wr_valid  = (state_q == S_WR_LO) || (state_q == S_WR_HI);
        sel_hi    = (state_q == S_WR_HI);
        load      = (state_q == S_ARM);
        advance   = (state_q == S_WR_HI) && wr_ready;
        done      = (state_q == S_DONE);
    end

    assign state = state_q;
endmodule

// File: rtl/pte_entry_gen.sv
module pte_entry_gen #(
    parameter int AW    = 64,
    parameter int DW    = 32,
    parameter int CNT_W = 19,
    parameter int STEP  = 8
) (
    input  logic             clk,
    input  logic             load,
    input  logic             advance,
    input  logic             sel_hi,
    input  logic [AW-1:0]    dest,
    input  logic [AW-1:0]    flags,
    input  logic [AW-1:0]    value,
    input  logic [AW-1:0]    stride,
    input  logic [CNT_W-1:0] count,
    output logic             last_entry,
    output logic [AW-1:0]    wr_addr,
    output logic [DW-1:0]    wr_data
);
    localparam logic [AW-1:0] ENTRY_STEP = AW'(STEP);
    localparam logic [AW-1:0] HALF_STEP  = AW'(STEP / 2);

    logic [AW-1:0]    addr_q, val_q;
    logic [CNT_W-1:0] left_q;
    logic [2*DW-1:0]  entry;

    always_ff @(posedge clk) begin
        if (load) begin
            addr_q <= dest;
            val_q  <= value;
            left_q <= count;
        end else if (advance) begin
            addr_q <= addr_q + ENTRY_STEP;
            val_q  <= val_q + stride;
            left_q <= left_q - 1'b1;
        end
    end

    assign entry      = val_q | flags;
    assign last_entry = (left_q == CNT_W'(1));
    assign wr_addr    = sel_hi ? addr_q + HALF_STEP : addr_q;
    assign wr_data    = sel_hi ? entry[2*DW-1:DW] : entry[DW-1:0];
endmodule

// File: rtl/pte_fill_engine.sv
module pte_fill_engine
    import pte_fill_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int DW    = WORD_W,
    parameter int CNT_W = COUNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [DW-1:0] cmd_dword,
    output logic          cmd_ready,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          done
);
    logic             last_word, last_entry, sel_hi, load, advance;
    logic [AW-1:0]    dest, flags, value, stride;
    logic [CNT_W-1:0] count;
    fill_state_e      state;

    pte_cmd_capture #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .NUM_WORDS(CMD_WORDS)) u_cap (
        .clk(clk), .rst_n(rst_n), .take(cmd_valid && cmd_ready), .word(cmd_dword),
        .last_word(last_word), .dest(dest), .flags(flags), .value(value),
        .stride(stride), .count(count)
    );

    pte_fill_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .last_word(last_word), .count_zero(count == '0),
        .last_entry(last_entry), .wr_ready(wr_ready), .state(state),
        .cmd_ready(cmd_ready), .wr_valid(wr_valid), .sel_hi(sel_hi),
        .load(load), .advance(advance), .done(done)
    );

    pte_entry_gen #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .STEP(ENTRY_BYTES)) u_gen (
        .clk(clk), .load(load), .advance(advance), .sel_hi(sel_hi),
        .dest(dest), .flags(flags), .value(value), .stride(stride), .count(count),
        .last_entry(last_entry), .wr_addr(wr_addr), .wr_data(wr_data)
    );
endmodule

// File: rtl/pte_fill_checker.sv
module pte_fill_checker #(
    parameter int AW = 64,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_ready,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          done
);
    // R7: a stalled write holds its request, address and data
    p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R8: done lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: no command intake while writes are outstanding
    p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ready && wr_valid));

    // R2: every write address is word aligned
    p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[1:0] == 2'b00));

    // R3: each accepted write is followed by none or by one 4 bytes higher
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (!wr_valid || (wr_addr == $past(wr_addr) + AW'(4))));

    // R8: cmd_ready returns right after done
    p_ready_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cmd_ready);
endmodule

bind pte_fill_engine pte_fill_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
);

// File: tb/sim_pte_fill_engine.sv
module sim_pte_fill_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_dword = '0;
    logic        cmd_ready;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [63:0] wr_addr;
    logic [31:0] wr_data;
    logic        done;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pte_fill_engine u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dword(cmd_dword),
        .cmd_ready(cmd_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
    );

    typedef struct packed {
        logic [63:0] dest;
        logic [63:0] flags;
        logic [63:0] value;
        logic [63:0] stride;
        logic [31:0] cnt_word;
        logic        stall;
        logic        junk;
        logic [31:0] exp_writes;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0001_0000_1000, 64'h1, 64'h0000_0000_4000_0000, 64'h1000,
          32'd4, 1'b0, 1'b0, 32'd8},
        '{64'h0000_0000_2000_0003, 64'h67, 64'h0000_0001_0000_0000, 64'h0000_0002_0000_0000,
          32'd3, 1'b1, 1'b1, 32'd6},
        '{64'hFFFF_FFFF_FFFF_FFF0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFF0, 64'h10,
          32'd3, 1'b1, 1'b0, 32'd6},
        '{64'h0000_0000_0000_8000, 64'h40, 64'h0, 64'h0,
          32'd2, 1'b0, 1'b1, 32'd4},
        '{64'h0000_0000_0000_0100, 64'h3, 64'h1_0000, 64'h1_0000,
          32'hFFF8_0002, 1'b1, 1'b0, 32'd4},
        '{64'h0000_0000_0000_0200, 64'h5, 64'h7, 64'h1,
          32'd0, 1'b0, 1'b1, 32'd0},
        '{64'h0000_0000_0000_0300, 64'h5, 64'h7, 64'h1,
          32'h0008_0000, 1'b0, 1'b0, 32'd0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_dword = w;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic send_cmd(input vec_t v);
        send_word(v.dest[31:0]);   send_word(v.dest[63:32]);
        send_word(v.flags[31:0]);  send_word(v.flags[63:32]);
        send_word(v.value[31:0]);  send_word(v.value[63:32]);
        send_word(v.stride[31:0]); send_word(v.stride[63:32]);
        send_word(v.cnt_word);
    endtask

    task automatic run_vec(input vec_t v);
        logic [63:0] n_ent, base, ent, e_addr;
        logic [31:0] e_data;
        int idx, cyc, nwr;
        bit acc;
        n_ent = 64'(v.cnt_word & 32'h7FFFF);
        nwr   = int'(n_ent) * 2;
        base  = {v.dest[63:2], 2'b00};
        chk(nwr == int'(v.exp_writes), "R5", "write count from count word",
            64'(nwr), 64'(v.exp_writes));
        send_cmd(v);
        idx = 0;
        cyc = 0;
        while (idx < nwr) begin
            @(negedge clk);
            wr_ready  = v.stall ? ((cyc % 3) != 0) : 1'b1;
            cmd_valid = v.junk;
            cmd_dword = 32'hDEAD_0000 + 32'(cyc);
            cyc++;
            chk(done == 1'b0, "R8", "done early", 64'(done), 64'd0);
            if (wr_valid) begin
                ent    = (v.value + 64'(idx / 2) * v.stride) | v.flags;
                e_addr = base + 64'(idx / 2) * 64'd8 + ((idx % 2) ? 64'd4 : 64'd0);
                e_data = (idx % 2) ? ent[63:32] : ent[31:0];
                chk(wr_addr == e_addr, "R2/R9", "write address", wr_addr, e_addr);
                chk(wr_data == e_data, "R3/R4", "write data", 64'(wr_data), 64'(e_data));
            end
            acc = wr_valid && wr_ready;
            @(posedge clk);
            if (acc) idx++;
        end
        if (nwr == 0) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            chk(done == 1'b0 && wr_valid == 1'b0, "R6", "zero count first cycle",
                64'({done, wr_valid}), 64'd0);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        wr_ready  = 1'b0;
        chk(done == 1'b1, "R8", "done after final write", 64'(done), 64'd1);
        chk(wr_valid == 1'b0, "R6", "no extra write", 64'(wr_valid), 64'd0);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done single cycle", 64'(done), 64'd0);
        chk(cmd_ready == 1'b1, "R8", "ready after done", 64'(cmd_ready), 64'd1);
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        chk(cmd_ready == 1'b1, "R10", "cmd_ready after reset", 64'(cmd_ready), 64'd1);
        chk(wr_valid == 1'b0, "R10", "wr_valid after reset", 64'(wr_valid), 64'd0);
        chk(done == 1'b0, "R10", "done after reset", 64'(done), 64'd0);

        // Table walk: R1 junk words ignored, R2..R9 patterns
        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R10: reset mid-command, then capture restarts at first word
        send_word(32'h0000_1000); send_word(32'h0);
        send_word(32'h0); send_word(32'h0);
        send_word(32'h0); send_word(32'h0);
        send_word(32'h8); send_word(32'h0);
        send_word(32'd5);
        @(negedge clk);
        cmd_valid = 1'b0;
        wr_ready  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(cmd_ready == 1'b1 && wr_valid == 1'b0 && done == 1'b0, "R10",
            "mid-run reset state", 64'({cmd_ready, wr_valid, done}), 64'b100);
        // partial command then reset: capture index must restart
        send_word(32'hAAAA_AAAA); send_word(32'hBBBB_BBBB);
        @(negedge clk);
        cmd_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_vec(VECS[0]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule